// File: doc/BRIEF.md
# Pixel-Port Select Function Decoder

This block sits in a video output pipeline just ahead of the colour lookup. Each accepted pixel beat carries a colour word and a two-bit port-select value. A two-bit function field decides what that port-select value means for the beat. It can be a device-select code compared against a local identity, where a mismatch shuts the channels off. It can be a switch between the palette colour mode and the bypass colour mode, with an overlay escape. It can be an overlay colour index. Or it can be ignored altogether. Every decision is made per beat, using the select bits and configuration present when that beat is accepted.

Beats enter and leave on valid/ready handshakes through a single output register, so results appear one clock after acceptance. The input is ready whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output data field holds still. Configuration pins and the configuration-error flag are plain signals. The flag reflects the configuration one clock after it is applied, whether or not beats are flowing. An 8:1 pseudo-colour indication borrows extra select inputs, and the switching function is not allowed in that case. If the switching function is requested anyway, the block treats the select bits as ignored and raises the error flag.

Top module: `ps_select_decoder`

## Requirements
- R1: With `cfg_func` = 3 (ignore), every beat yields `out_src` = 0 (pixel), `out_color` equal to the input colour, `out_mode` equal to `cfg_pal_mode`, `out_bypass` = 0, `out_ovl_idx` = 0 and `out_shutdown` = 0.
- R2: With `cfg_func` = 0 (device select), a beat whose `in_sel` equals `cfg_dev_id` passes as in R1. On a mismatch the beat yields `out_src` = 2 (off), `out_shutdown` = 1 and `out_color` = 0, whatever the colour input is.
- R3: With `cfg_func` = 2 (overlay), `in_sel` = 0 passes the pixel as in R1. Any other value yields `out_src` = 1 (overlay), `out_ovl_idx` = `in_sel` and `out_color` = 0.
- R4: With `cfg_func` = 1 (palette/bypass switch) and `pseudo8` = 0, `in_sel[0]` = 1 yields overlay index 1, whatever `in_sel[1]` is. `in_sel` = 0 yields the pixel with `out_mode` = `cfg_pal_mode` and `out_bypass` = 0. `in_sel` = 2 yields the pixel with `out_mode` = `cfg_byp_mode` zero-extended and `out_bypass` = 1.
- R5: With `cfg_func` = 1 and `pseudo8` = 1, beats are decoded as in R1, and `cfg_err` is 1 one clock later. `cfg_err` is 0 one clock after any other configuration.
- R6: Each beat is decoded with the `in_sel` and configuration values present in the cycle it is accepted, so those values may change on every beat.
- R7: A beat accepted at a rising edge appears on the outputs with `out_valid` = 1 after that same edge. `in_ready` equals `!out_valid || out_ready`.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid` and all output data fields keep their values into the next cycle.
- R9: While `rst_n` is low, `out_valid`, `cfg_err` and `out_shutdown` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_color | input | COLOR_W | Pixel colour word |
| in_sel | input | 2 | Per-pixel port-select bits {PS1, PS0} |
| cfg_func | input | 2 | Select function: 0 device select, 1 palette/bypass switch, 2 overlay, 3 ignore |
| cfg_dev_id | input | 2 | Local identity for device select |
| cfg_pal_mode | input | 4 | Palette colour mode code |
| cfg_byp_mode | input | 2 | Bypass colour mode code |
| pseudo8 | input | 1 | 8:1 pseudo-colour operation active |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_color | output | COLOR_W | Colour word, zero unless source is pixel |
| out_src | output | 2 | Source: 0 pixel, 1 overlay, 2 off |
| out_ovl_idx | output | 2 | Overlay colour index, 0 unless source is overlay |
| out_mode | output | 4 | Active colour mode code |
| out_bypass | output | 1 | out_mode holds a bypass code |
| out_shutdown | output | 1 | Channel outputs forced off |
| cfg_err | output | 1 | Switch function requested during pseudo-colour |

## Verification
Back-pressure and reconfiguration can fall in the same cycle. A beat can be stalled in the output register while the next beat, carrying a different function field and select value, is already presented. The bench drives `out_ready` from a random pattern while it changes the configuration on every beat. This way held results must stay frozen, and the waiting beat must be decoded with its own configuration when it is finally accepted. The scoreboard judges each delivered beat against a model built from the requirements. The monitor also compares every stalled cycle against the values of the previous cycle. The error flag can also rise in a cycle where the output is stalled. It is checked against the configuration applied in the cycle before.

// File: rtl/ps_sel_pkg.sv
package ps_sel_pkg;
  localparam int SEL_W  = 2;
  localparam int PAL_W  = 4;
  localparam int BYP_W  = 2;
  localparam int FUNC_W = 2;

  typedef enum logic [1:0] {
    SRC_PIXEL   = 2'd0,
    SRC_OVERLAY = 2'd1,
    SRC_OFF     = 2'd2
  } src_e;

  typedef enum logic [FUNC_W-1:0] {
    FN_DEVSEL  = 2'd0,
    FN_SWITCH  = 2'd1,
    FN_OVERLAY = 2'd2,
    FN_IGNORE  = 2'd3
  } func_e;

  typedef struct packed {
    src_e             src;
    logic [SEL_W-1:0] ovl;
    logic             byp;
    logic [PAL_W-1:0] mode;
    logic             shut;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/ps_cfg_guard.sv
module ps_cfg_guard
  import ps_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FUNC_W-1:0] func_raw,
  input  logic              pseudo8,
  output func_e             func_eff,
  output logic              err_q
);
  logic illegal;

  assign illegal  = (func_e'(func_raw) == FN_SWITCH) && pseudo8;
  assign func_eff = illegal ? FN_IGNORE : func_e'(func_raw);

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= illegal;
  end
endmodule

// File: rtl/ps_decode.sv
module ps_decode
  import ps_sel_pkg::*;
(
  input  func_e            func,
  input  logic [SEL_W-1:0] sel,
  input  logic [SEL_W-1:0] dev_id,
  input  logic [PAL_W-1:0] pal_mode,
  input  logic [BYP_W-1:0] byp_mode,
  output ctl_t             ctl
);
  always_comb begin
    ctl      = '0;
    ctl.src  = SRC_PIXEL;
    ctl.mode = pal_mode;
    unique case (func)
      FN_DEVSEL: begin
        if (sel != dev_id) begin
          ctl.src  = SRC_OFF;
          ctl.shut = 1'b1;
        end
      end
      FN_SWITCH: begin
        if (sel[0]) begin
          ctl.src = SRC_OVERLAY;
          ctl.ovl = SEL_W'(1);
        end else if (sel[1]) begin
          ctl.byp  = 1'b1;
          ctl.mode = PAL_W'(byp_mode);
        end
      end
      FN_OVERLAY: begin
        if (sel != '0) begin
          ctl.src = SRC_OVERLAY;
          ctl.ovl = sel;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ps_stage.sv
module ps_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign s_ready = !vld_q || m_ready;
  assign m_valid = vld_q;
  assign m_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (s_ready) begin
      vld_q <= s_valid;
      if (s_valid) dat_q <= s_data;
    end
  end
endmodule

// File: rtl/ps_select_decoder.sv
module ps_select_decoder
  import ps_sel_pkg::*;
#(
  parameter int COLOR_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [COLOR_W-1:0]    in_color,
  input  logic [SEL_W-1:0]      in_sel,
  input  logic [FUNC_W-1:0]     cfg_func,
  input  logic [SEL_W-1:0]      cfg_dev_id,
  input  logic [PAL_W-1:0]      cfg_pal_mode,
  input  logic [BYP_W-1:0]      cfg_byp_mode,
  input  logic                  pseudo8,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [COLOR_W-1:0]    out_color,
  output logic [1:0]            out_src,
  output logic [SEL_W-1:0]      out_ovl_idx,
  output logic [PAL_W-1:0]      out_mode,
  output logic                  out_bypass,
  output logic                  out_shutdown,
  output logic                  cfg_err
);
  localparam int PW = CTL_W + COLOR_W;

  func_e              func_eff;
  ctl_t               ctl_d, ctl_q;
  logic [COLOR_W-1:0] color_d, color_q;
  logic [PW-1:0]      pack_d, pack_q;

  ps_cfg_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .func_raw (cfg_func),
    .pseudo8  (pseudo8),
    .func_eff (func_eff),
    .err_q    (cfg_err)
  );

  ps_decode u_dec (
    .func     (func_eff),
    .sel      (in_sel),
    .dev_id   (cfg_dev_id),
    .pal_mode (cfg_pal_mode),
    .byp_mode (cfg_byp_mode),
    .ctl      (ctl_d)
  );

  assign color_d = (ctl_d.src == SRC_PIXEL) ? in_color : '0;
  assign pack_d  = {ctl_d, color_d};

  ps_stage #(.W(PW)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (pack_d),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pack_q)
  );

  assign {ctl_q, color_q} = pack_q;
  assign out_color    = color_q;
  assign out_src      = ctl_q.src;
  assign out_ovl_idx  = ctl_q.ovl;
  assign out_mode     = ctl_q.mode;
  assign out_bypass   = ctl_q.byp;
  assign out_shutdown = ctl_q.shut;
endmodule

// File: rtl/ps_select_decoder_chk.sv
module ps_select_decoder_chk #(
  parameter int COLOR_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [COLOR_W-1:0] in_color,
  input logic [1:0]         in_sel,
  input logic [1:0]         cfg_func,
  input logic [1:0]         cfg_dev_id,
  input logic [3:0]         cfg_pal_mode,
  input logic [1:0]         cfg_byp_mode,
  input logic               pseudo8,
  input logic               out_valid,
  input logic               out_ready,
  input logic [COLOR_W-1:0] out_color,
  input logic [1:0]         out_src,
  input logic [1:0]         out_ovl_idx,
  input logic [3:0]         out_mode,
  input logic               out_bypass,
  input logic               out_shutdown,
  input logic               cfg_err
);
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_shutdown |-> out_src == 2'd2 && out_color == '0); // R2
  AST_OVL_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_src == 2'd1 |-> out_ovl_idx != 2'd0 && out_color == '0); // R3
  AST_BYP_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bypass |-> out_src == 2'd0 && !out_shutdown); // R4
  AST_CFG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_func) == 2'd1 && $past(pseudo8)); // R5
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_color) && $stable(out_src)
      && $stable(out_ovl_idx) && $stable(out_mode) && $stable(out_bypass)
      && $stable(out_shutdown)); // R8
endmodule

bind ps_select_decoder ps_select_decoder_chk #(.COLOR_W(COLOR_W)) u_chk (.*);

// File: tb/ps_select_decoder_test.sv
module ps_select_decoder_test;
  localparam int CW = 24;

  typedef struct {
    logic [CW-1:0] color;
    logic [1:0]    src;
    logic [1:0]    idx;
    logic [3:0]    mode;
    logic          byp;
    logic          shut;
    string         tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [CW-1:0] in_color = '0, out_color;
  logic [1:0] in_sel = 0, cfg_func = 3, cfg_dev_id = 0, cfg_byp_mode = 0;
  logic [3:0] cfg_pal_mode = 0, out_mode;
  logic pseudo8 = 0, out_bypass, out_shutdown, cfg_err;
  logic [1:0] out_src, out_ovl_idx;

  int total = 0, bad = 0;
  bit ready_rand = 0, done = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  ps_select_decoder #(.COLOR_W(CW)) uut (.*);

  function automatic exp_t model(logic [CW-1:0] c, logic [1:0] s, logic [1:0] f,
                                 logic [1:0] id, logic [3:0] pm, logic [1:0] bm,
                                 logic p8, string tag);
    exp_t e;
    logic [1:0] fe;
    e.color = c; e.src = 0; e.idx = 0; e.mode = pm; e.byp = 0; e.shut = 0; e.tag = tag;
    fe = (f == 2'd1 && p8) ? 2'd3 : f;
    case (fe)
      2'd0: if (s != id) begin e.src = 2; e.shut = 1; e.color = '0; end
      2'd1: if (s[0]) begin e.src = 1; e.idx = 1; e.color = '0; end
            else if (s[1]) begin e.byp = 1; e.mode = {2'b00, bm}; end
      2'd2: if (s != 0) begin e.src = 1; e.idx = s; e.color = '0; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic send(logic [CW-1:0] c, logic [1:0] s, logic [1:0] f, logic [1:0] id,
                      logic [3:0] pm, logic [1:0] bm, logic p8, string tag);
    @(negedge clk);
    in_color = c; in_sel = s; cfg_func = f; cfg_dev_id = id;
    cfg_pal_mode = pm; cfg_byp_mode = bm; pseudo8 = p8; in_valid = 1;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    q.push_back(model(c, s, f, id, pm, bm, p8, tag));
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  // monitor / scoreboard
  logic [CW+11:0] held;
  bit hold_pend = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        check(out_valid && {out_color, out_src, out_ovl_idx, out_mode, out_bypass, out_shutdown} == held,
              "R8", "stalled outputs", {out_color, out_src}, held[CW+11:8]);
      out_ready = ready_rand ? ($urandom_range(0, 2) != 0) : 1'b1;
      hold_pend = 0;
      if (out_valid && out_ready) begin
        if (q.size() == 0) check(0, "R7", "unexpected beat", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(out_color == e.color, e.tag, "color", out_color, e.color);
          check(out_src == e.src && out_ovl_idx == e.idx, e.tag, "src/idx",
                {out_src, out_ovl_idx}, {e.src, e.idx});
          check(out_mode == e.mode && out_bypass == e.byp && out_shutdown == e.shut, e.tag,
                "mode/byp/shut", {out_mode, out_bypass, out_shutdown}, {e.mode, e.byp, e.shut});
        end
      end else if (out_valid) begin
        held = {out_color, out_src, out_ovl_idx, out_mode, out_bypass, out_shutdown};
        hold_pend = 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cfg_func = 2'd1; pseudo8 = 1;
    repeat (3) @(negedge clk);
    check(!out_valid && !cfg_err && !out_shutdown, "R9", "reset outputs",
          {out_valid, cfg_err, out_shutdown}, 0);
    cfg_func = 2'd3; pseudo8 = 0;
    @(negedge clk) rst_n = 1;

    // R1 ignore
    send(24'h123456, 2'd0, 2'd3, 2'd2, 4'h5, 2'd1, 0, "R1");
    send(24'hABCDEF, 2'd3, 2'd3, 2'd2, 4'h9, 2'd3, 0, "R1");
    // R2 device select
    send(24'h111111, 2'd2, 2'd0, 2'd2, 4'h3, 2'd0, 0, "R2");
    send(24'hFFFFFF, 2'd1, 2'd0, 2'd2, 4'h3, 2'd0, 0, "R2");
    send(24'h0F0F0F, 2'd0, 2'd0, 2'd3, 4'h3, 2'd0, 0, "R2");
    // R3 overlay
    for (int i = 0; i < 4; i++) send(24'h55AA55 + i, 2'(i), 2'd2, 2'd0, 4'hC, 2'd2, 0, "R3");
    // R4 switch
    for (int i = 0; i < 4; i++) send(24'h777000 + i, 2'(i), 2'd1, 2'd0, 4'hE, 2'd2, 0, "R4");
    // R5 pseudo-colour fallback and flag
    send(24'h202020, 2'd2, 2'd1, 2'd0, 4'h6, 2'd3, 1, "R5");
    @(negedge clk);
    check(cfg_err == 1, "R5", "cfg_err set", cfg_err, 1);
    cfg_func = 2'd2;
    @(negedge clk);
    check(cfg_err == 0, "R5", "cfg_err clear", cfg_err, 0);
    // R7 latency
    send(24'h0A0B0C, 2'd1, 2'd3, 2'd0, 4'h1, 2'd0, 0, "R7");
    @(negedge clk);
    check(out_valid == 1 && out_color == 24'h0A0B0C, "R7", "one-cycle latency",
          {out_valid, out_color}, {1'b1, 24'h0A0B0C});
    // R6 / R8 random per-beat config under back-pressure
    ready_rand = 1;
    for (int n = 0; n < 400; n++)
      send(CW'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
           4'($urandom), 2'($urandom), 1'($urandom), "R6");
    for (int k = 0; k < 200 && q.size() != 0; k++) @(negedge clk);
    ready_rand = 0;
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R7", "all beats delivered", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule